// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block sits between a USB serial engine and a CPU for one bulk- or interrupt-style endpoint. For each token the host sends, it chooses the reply. Host-to-device (OUT) data is acknowledged and stored only when the endpoint buffer is empty. Device-to-host (IN) data is sent only after firmware has armed the buffer. In every other case the host receives NAK and retries later, so the pace of the transfer follows the pace of the firmware.

The serial engine delivers these events as one-cycle strobes:
- a token strobe, with a direction bit;
- a data-packet strobe, with the packet's data PID;
- a host acknowledge strobe after an IN data packet.

The controller answers with a registered handshake strobe (ACK or NAK) or a registered request to transmit the IN payload with a chosen PID. It keeps a separate data toggle for each direction.

The CPU owns three strobes: release the received buffer, arm the transmit buffer, and clear the transmit-complete flag. The received flag and the transmit-complete flag, gated by an enable, form the endpoint interrupt request. A synchronous endpoint reset returns the endpoint to a clean DATA0 state.

Top module: `usb_ep_handshake`

## Requirements
- R1: An OUT data packet that arrives with the buffer empty and a PID equal to the expected toggle (0 = DATA0, 1 = DATA1) produces `hs_valid`=1 with `hs_nak`=0 one cycle later. In the same cycle `rx_full` rises and the expected OUT toggle flips.
- R2: While `rx_full` is 1, every OUT data packet gets `hs_valid`=1 with `hs_nak`=1. `rx_full` and the OUT toggle are left unchanged.
- R3: A `rx_release` strobe clears `rx_full`. The next OUT data packet carrying the flipped toggle (DATA1 after a first DATA0) is then acknowledged and stored.
- R4: An IN token that arrives while `tx_ready` is 0 gets `hs_valid`=1 with `hs_nak`=1 one cycle later.
- R5: An IN token that arrives while `tx_ready` is 1 produces `tx_send`=1 one cycle later, with `tx_pid` equal to the IN toggle (DATA0 after reset). No handshake is issued in that cycle.
- R6: A `host_ack` that arrives while IN data is outstanding clears `tx_ready`, sets `tx_done` and flips the IN toggle. All three changes are visible one cycle later.
- R7: If no `host_ack` arrives within `RESP_TIMEOUT` cycles after an IN payload is sent, the endpoint returns to idle with `tx_ready` still 1. The next IN token resends the payload with the same PID.
- R8: An OUT data packet whose PID differs from the expected toggle, arriving with the buffer empty, is ACKed. It does not set `rx_full` and does not flip the toggle.
- R9: Reset and the synchronous `ep_reset` input both clear `rx_full`, `tx_ready` and `tx_done`, and force both toggles to DATA0.
- R10: `irq` is 1 exactly when `irq_en` is 1 and either `rx_full` or `tx_done` is 1.
- R11: A data packet that does not follow an OUT token within `RESP_TIMEOUT` cycles is ignored. It produces no handshake and does not change `rx_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| ep_reset | input | 1 | Synchronous endpoint reset strobe |
| tok_valid | input | 1 | Token received strobe |
| tok_in | input | 1 | Token direction: 1 = IN, 0 = OUT |
| pkt_valid | input | 1 | Valid OUT data packet strobe |
| pkt_pid | input | 1 | Data PID of the packet: 0 = DATA0, 1 = DATA1 |
| host_ack | input | 1 | Host acknowledged the IN data packet |
| rx_release | input | 1 | CPU finished reading the OUT buffer |
| tx_arm | input | 1 | CPU wrote the IN buffer and marks it ready |
| tx_done_clr | input | 1 | CPU clears the transmit-complete flag |
| irq_en | input | 1 | Endpoint interrupt enable |
| hs_valid | output | 1 | Handshake to send this cycle |
| hs_nak | output | 1 | Handshake kind: 1 = NAK, 0 = ACK |
| tx_send | output | 1 | Send the IN payload now |
| tx_pid | output | 1 | Data PID for the IN payload |
| rx_full | output | 1 | OUT buffer holds a received packet |
| tx_ready | output | 1 | IN buffer armed by the CPU |
| tx_done | output | 1 | IN payload acknowledged by the host |
| irq | output | 1 | Endpoint interrupt request |

## Verification
The bench builds the block with `RESP_TIMEOUT` set to 8, not the default of 64. This keeps both waiting windows short: the wait for a host ACK after sending IN data, and the wait for a data packet after an OUT token. With windows that short, the bench can exercise the resend-with-same-PID path and the stray-data-after-timeout path in a handful of idle cycles. It can also run several full transfers in each direction, so that the toggle is seen to alternate and to return to DATA0 after an endpoint reset.

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake #(
  parameter int RESP_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ep_reset,
  input  logic tok_valid,
  input  logic tok_in,
  input  logic pkt_valid,
  input  logic pkt_pid,
  input  logic host_ack,
  input  logic rx_release,
  input  logic tx_arm,
  input  logic tx_done_clr,
  input  logic irq_en,
  output logic hs_valid,
  output logic hs_nak,
  output logic tx_send,
  output logic tx_pid,
  output logic rx_full,
  output logic tx_ready,
  output logic tx_done,
  output logic irq
);
  localparam int CW = $clog2(RESP_TIMEOUT + 1);
  localparam logic [CW-1:0] LIM = CW'(RESP_TIMEOUT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_OUT, ST_IN} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic         out_tog, in_tog;

  assign irq = irq_en & (rx_full | tx_done);

  always_ff @(posedge clk) begin
    if (!rst_n || ep_reset) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      out_tog  <= 1'b0;
      in_tog   <= 1'b0;
      hs_valid <= 1'b0;
      hs_nak   <= 1'b0;
      tx_send  <= 1'b0;
      tx_pid   <= 1'b0;
      rx_full  <= 1'b0;
      tx_ready <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      hs_valid <= 1'b0;
      hs_nak   <= 1'b0;
      tx_send  <= 1'b0;
      if (rx_release)  rx_full  <= 1'b0;
      if (tx_arm)      tx_ready <= 1'b1;
      if (tx_done_clr) tx_done  <= 1'b0;
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (tok_valid) begin
            if (tok_in) begin
              if (tx_ready) begin
                tx_send <= 1'b1;
                tx_pid  <= in_tog;
                st      <= ST_IN;
              end else begin
                hs_valid <= 1'b1;
                hs_nak   <= 1'b1;
              end
            end else begin
              st <= ST_OUT;
            end
          end
        end
        ST_OUT: begin
          if (pkt_valid) begin
            st       <= ST_IDLE;
            hs_valid <= 1'b1;
            if (rx_full) begin
              hs_nak <= 1'b1;
            end else if (pkt_pid == out_tog) begin
              rx_full <= 1'b1;
              out_tog <= ~out_tog;
            end
          end else if (cnt == LIM) begin
            st <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IN: begin
          if (host_ack) begin
            tx_ready <= 1'b0;
            tx_done  <= 1'b1;
            in_tog   <= ~in_tog;
            st       <= ST_IDLE;
          end else if (cnt == LIM) begin
            st <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_ep_handshake_chk.sv
module usb_ep_handshake_chk (
  input logic clk,
  input logic rst_n,
  input logic ep_reset,
  input logic irq_en,
  input logic hs_valid,
  input logic hs_nak,
  input logic tx_send,
  input logic rx_full,
  input logic tx_ready,
  input logic tx_done,
  input logic irq
);
  p_full_rises_with_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> (hs_valid && !hs_nak));

  p_send_only_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send |-> tx_ready);

  p_send_excludes_handshake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_send && hs_valid));

  p_done_frees_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> !tx_ready);

  p_ep_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ep_reset) |-> (!rx_full && !tx_ready && !tx_done && !hs_valid && !tx_send));

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
endmodule

bind usb_ep_handshake usb_ep_handshake_chk u_chk (.*);

// File: tb/sim_usb_ep_handshake.sv
module sim_usb_ep_handshake;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;

  localparam logic [2:0] OP_NOP = 3'd0, OP_OTOK = 3'd1, OP_DATA = 3'd2, OP_ITOK = 3'd3,
                         OP_ACK = 3'd4, OP_REL = 3'd5, OP_ARM = 3'd6, OP_DCLR = 3'd7;

  // {op[2:0], pid, exp hs_valid, hs_nak, tx_send, tx_pid, rx_full, tx_ready, tx_done}
  localparam logic [10:0] VEC [0:22] = '{
    {3'd3, 1'b0, 7'b1100000},  // R4 IN with nothing armed -> NAK
    {3'd1, 1'b0, 7'b0000000},
    {3'd2, 1'b0, 7'b1000100},  // R1 DATA0 accepted
    {3'd1, 1'b0, 7'b0000100},
    {3'd2, 1'b1, 7'b1100100},  // R2 buffer busy -> NAK
    {3'd5, 1'b0, 7'b0000000},
    {3'd1, 1'b0, 7'b0000000},
    {3'd2, 1'b1, 7'b1000100},  // R3 DATA1 accepted after release
    {3'd5, 1'b0, 7'b0000000},
    {3'd1, 1'b0, 7'b0000000},
    {3'd2, 1'b1, 7'b1000000},  // R8 wrong toggle: ACK, discarded
    {3'd1, 1'b0, 7'b0000000},
    {3'd2, 1'b0, 7'b1000100},  // R8 toggle did not advance
    {3'd5, 1'b0, 7'b0000000},
    {3'd6, 1'b0, 7'b0000010},
    {3'd3, 1'b0, 7'b0010010},  // R5 send DATA0
    {3'd4, 1'b0, 7'b0000001},  // R6 host ACK
    {3'd7, 1'b0, 7'b0000000},
    {3'd6, 1'b0, 7'b0000010},
    {3'd3, 1'b0, 7'b0011010},  // R5 send DATA1
    {3'd4, 1'b0, 7'b0000001},  // R6
    {3'd7, 1'b0, 7'b0000000},
    {3'd2, 1'b0, 7'b0000000}   // R11 data with no OUT token
  };

  logic clk = 1'b0, rst_n = 1'b0, ep_reset = 1'b0;
  logic tok_valid = 1'b0, tok_in = 1'b0, pkt_valid = 1'b0, pkt_pid = 1'b0, host_ack = 1'b0;
  logic rx_release = 1'b0, tx_arm = 1'b0, tx_done_clr = 1'b0, irq_en = 1'b1;
  logic hs_valid, hs_nak, tx_send, tx_pid, rx_full, tx_ready, tx_done, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usb_ep_handshake #(.RESP_TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset), .tok_valid(tok_valid), .tok_in(tok_in),
    .pkt_valid(pkt_valid), .pkt_pid(pkt_pid), .host_ack(host_ack), .rx_release(rx_release),
    .tx_arm(tx_arm), .tx_done_clr(tx_done_clr), .irq_en(irq_en), .hs_valid(hs_valid),
    .hs_nak(hs_nak), .tx_send(tx_send), .tx_pid(tx_pid), .rx_full(rx_full),
    .tx_ready(tx_ready), .tx_done(tx_done), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic pid);
    @(negedge clk);
    tok_valid   = (op == OP_OTOK) || (op == OP_ITOK);
    tok_in      = (op == OP_ITOK);
    pkt_valid   = (op == OP_DATA);
    pkt_pid     = pid;
    host_ack    = (op == OP_ACK);
    rx_release  = (op == OP_REL);
    tx_arm      = (op == OP_ARM);
    tx_done_clr = (op == OP_DCLR);
    @(posedge clk);
    #1;
    {tok_valid, tok_in, pkt_valid, pkt_pid, host_ack, rx_release, tx_arm, tx_done_clr} = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(OP_NOP, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check("R9 reset state", {hs_valid, hs_nak, tx_send, rx_full, tx_ready, tx_done, irq, 1'b0}, 8'h00);

    for (int v = 0; v < 23; v++) begin
      logic [6:0] e;
      e = VEC[v][6:0];
      step(VEC[v][10:8], VEC[v][7]);
      check($sformatf("vector %0d (R1-R11 table)", v),
            {hs_valid, hs_nak, tx_send, tx_send ? tx_pid : 1'b0, rx_full, tx_ready, tx_done, irq},
            {e, e[2] | e[0]});
    end

    // R7 timeout resend with same PID (IN toggle back at DATA0)
    step(OP_ARM, 1'b0);
    step(OP_ITOK, 1'b0);
    check("R7 first send", {6'b0, tx_send, tx_pid}, 8'b10);
    idle(TMO + 2);
    check("R7 still armed after timeout", {7'b0, tx_ready}, 8'b1);
    step(OP_ITOK, 1'b0);
    check("R7 resend same PID", {5'b0, tx_send, tx_pid, hs_valid}, 8'b100);
    step(OP_ACK, 1'b0);
    check("R6 ack after resend", {6'b0, tx_ready, tx_done}, 8'b01);

    // R10 interrupt gating
    @(negedge clk);
    irq_en = 1'b0;
    #1;
    check("R10 irq masked", {7'b0, irq}, 8'b0);
    irq_en = 1'b1;
    #1;
    check("R10 irq enabled", {7'b0, irq}, 8'b1);
    step(OP_DCLR, 1'b0);
    check("R10 irq drops with flag", {6'b0, tx_done, irq}, 8'b0);

    // R11 data arriving after OUT token timeout (OUT toggle expects DATA1)
    step(OP_OTOK, 1'b0);
    idle(TMO + 2);
    step(OP_DATA, 1'b1);
    check("R11 late data ignored", {6'b0, hs_valid, rx_full}, 8'b0);
    step(OP_OTOK, 1'b0);
    step(OP_DATA, 1'b1);
    check("R1 DATA1 accepted", {5'b0, hs_valid, hs_nak, rx_full}, 8'b101);

    // R9 endpoint reset
    step(OP_ARM, 1'b0);
    step(OP_ACK, 1'b0);
    step(OP_ARM, 1'b0);
    @(negedge clk);
    ep_reset = 1'b1;
    @(posedge clk);
    #1;
    ep_reset = 1'b0;
    check("R9 ep_reset clears flags", {5'b0, rx_full, tx_ready, tx_done}, 8'b0);
    step(OP_OTOK, 1'b0);
    step(OP_DATA, 1'b1);
    check("R9 OUT toggle back to DATA0 (DATA1 discarded)", {5'b0, hs_valid, hs_nak, rx_full}, 8'b100);
    step(OP_OTOK, 1'b0);
    step(OP_DATA, 1'b0);
    check("R9 DATA0 accepted after ep_reset", {7'b0, rx_full}, 8'b1);
    step(OP_ARM, 1'b0);
    step(OP_ITOK, 1'b0);
    check("R9 IN toggle back to DATA0", {6'b0, tx_send, tx_pid}, 8'b10);
    step(OP_ACK, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule